// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Execute Unit

This block is the combinational execute stage for the arithmetic instruction class of a packet-filter virtual machine. The issue logic presents an 8-bit opcode, the current destination register value, the source register value and the 32-bit immediate. In the same cycle the block returns the value to write back into the destination register, together with an invalid flag for encodings it does not support.

The opcode has three fields. The upper nibble selects the operation. Bit 3 selects the source operand. The low three bits give the class: a 32-bit word class or a 64-bit class. Ordinary operations (add, subtract, multiply, xor, move, arithmetic shift right) combine the destination with either the source register or the sign-extended immediate. The byte-swap operation works differently. It uses bit 3 to pick the target byte order and the immediate to pick the conversion width. It reads only the destination register. The host byte order is taken as little endian.

Top module: `alu_exec`

## Requirements
- R1: Operation nibble `opcode[7:4]` selects add 0x0, subtract 0x1, multiply 0x2, xor 0xA, move 0xB, arithmetic shift right 0xC and byte swap 0xD. Each computes `dst op operand`, and move returns the operand. Arithmetic wraps modulo the operand width.
- R2: Class field `opcode[2:0]` = 3'h4 selects 32-bit word operation and 3'h7 selects 64-bit operation. Any other class value is invalid.
- R3: For ordinary operations, `opcode[3]`=1 takes `src_in` as the operand. `opcode[3]`=0 takes the immediate, sign-extended from bit 31 to 64 bits.
- R4: In the 32-bit class, ordinary operations use the low 32 bits of both operands. The 32-bit result is zero-extended into `dst_out`.
- R5: Arithmetic shift right fills with the sign bit (bit 31 in the 32-bit class, bit 63 in the 64-bit class). The shift amount is the operand masked to 5 bits (32-bit class) or 6 bits (64-bit class).
- R6: Byte swap with `opcode[3]`=0 (little endian) returns the low 16, 32 or 64 bits of `dst_in`, zero-extended. The width comes from `imm` = 16, 32 or 64.
- R7: Byte swap with `opcode[3]`=1 (big endian) returns the low 16, 32 or 64 bits of `dst_in` with the byte order reversed, zero-extended.
- R8: Byte swap result does not depend on `src_in`.
- R9: An unsupported operation nibble, a swap width other than 16/32/64, byte swap in the 64-bit class, or an unsupported class sets `invalid`=1 with `dst_out` equal to `dst_in`.
- R10: Every supported encoding gives `invalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Operation nibble, source/order bit, class |
| dst_in | input | 64 | Current destination register value |
| src_in | input | 64 | Source register value |
| imm | input | 32 | Immediate field (operand or swap width) |
| dst_out | output | 64 | New destination value |
| invalid | output | 1 | Unsupported encoding flag |

## Verification
All results are combinational, so `dst_out` and `invalid` are due in the same cycle the inputs are applied, with no register on the path. The bench changes inputs on the falling clock edge and samples just after the next rising edge. Each output has therefore settled a half period after its stimulus before it is compared.

The sweep covers all 256 opcodes against several operand patterns. For swap opcodes it also varies the immediate over valid and invalid widths. Each result is compared with an arithmetic model written in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // operation nibble codes
  localparam logic [3:0] OPN_ADD  = 4'h0;
  localparam logic [3:0] OPN_SUB  = 4'h1;
  localparam logic [3:0] OPN_MUL  = 4'h2;
  localparam logic [3:0] OPN_XOR  = 4'hA;
  localparam logic [3:0] OPN_MOV  = 4'hB;
  localparam logic [3:0] OPN_ARSH = 4'hC;
  localparam logic [3:0] OPN_SWAP = 4'hD;

  // class codes
  localparam logic [2:0] CLS_WORD = 3'h4;
  localparam logic [2:0] CLS_WIDE = 3'h7;

  // one-hot operation selection
  typedef struct packed {
    logic is_add;
    logic is_sub;
    logic is_mul;
    logic is_xor;
    logic is_mov;
    logic is_arsh;
    logic is_swap;
  } opsel_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [7:0] opcode,
  output opsel_t     sel,
  output logic       use_reg,
  output logic       word32,
  output logic       bad_class,
  output logic       bad_op
);

  logic [3:0] nib;
  logic [2:0] cls;
  logic       known;

  assign nib     = opcode[7:4];
  assign cls     = opcode[2:0];
  assign use_reg = opcode[3];
  assign word32  = (cls == CLS_WORD);

  always_comb begin
    sel   = '0;
    known = 1'b1;
    unique case (nib)
      OPN_ADD:  sel.is_add  = 1'b1;
      OPN_SUB:  sel.is_sub  = 1'b1;
      OPN_MUL:  sel.is_mul  = 1'b1;
      OPN_XOR:  sel.is_xor  = 1'b1;
      OPN_MOV:  sel.is_mov  = 1'b1;
      OPN_ARSH: sel.is_arsh = 1'b1;
      OPN_SWAP: sel.is_swap = 1'b1;
      default:  known       = 1'b0;
    endcase
  end

  assign bad_class = !((cls == CLS_WORD) || (cls == CLS_WIDE));
  // byte swap exists only in the word class
  assign bad_op    = !known || (sel.is_swap && !word32);

  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_sel_onehot_R1: assert ($onehot0(sel))
        else $error("decode selected more than one operation");
      if (!known)
        assert_unknown_nosel_R9: assert (sel == '0)
          else $error("unknown nibble selected an operation");
    end
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DW = 64
) (
  input  opsel_t          sel,
  input  logic            word32,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res
);

  localparam int HW  = DW / 2;
  localparam int SHW = $clog2(DW);

  // keep the low half and clear the rest when in word mode
  function automatic logic [DW-1:0] f_narrow(input logic [DW-1:0] x, input logic w);
    return w ? {{(DW-HW){1'b0}}, x[HW-1:0]} : x;
  endfunction

  function automatic logic [DW-1:0] f_arsh(input logic [DW-1:0] x,
                                           input logic [DW-1:0] amt_src,
                                           input logic          w);
    logic signed [DW-1:0] sx;
    logic [SHW-1:0]       amt;
    sx  = w ? {{(DW-HW){x[HW-1]}}, x[HW-1:0]} : x;
    amt = w ? {1'b0, amt_src[SHW-2:0]} : amt_src[SHW-1:0];
    return sx >>> amt;
  endfunction

  logic [DW-1:0] raw;

  always_comb begin
    raw = '0;
    if (sel.is_add)  raw = a + b;
    if (sel.is_sub)  raw = a - b;
    if (sel.is_mul)  raw = a * b;
    if (sel.is_xor)  raw = a ^ b;
    if (sel.is_mov)  raw = b;
    if (sel.is_arsh) raw = f_arsh(a, b, word32);
  end

  assign res = f_narrow(raw, word32);

  always_comb begin
    if (sel.is_arsh && !word32 && a[DW-1] && (b[SHW-1:0] == SHW'(DW-1)))
      assert_arsh_fill_R5: assert (&res)
        else $error("full shift of a negative value lost sign fill");
  end

endmodule

// File: rtl/alu_byteswap.sv
module alu_byteswap #(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input  logic [DW-1:0] val,
  input  logic          big,
  input  logic [IW-1:0] width,
  output logic [DW-1:0] res,
  output logic          width_bad
);

  localparam int NW = 3; // 16, 32, 64 bit swap widths

  logic [DW-1:0] rev_arr  [NW];
  logic [DW-1:0] keep_arr [NW];
  logic [NW-1:0] wsel;

  for (genvar w = 0; w < NW; w++) begin : g_width
    localparam int NB = 2 << w;
    logic [DW-1:0] rev;
    always_comb begin
      rev = '0;
      for (int j = 0; j < NB; j++)
        rev[8*j +: 8] = val[8*(NB-1-j) +: 8];
    end
    assign rev_arr[w]  = rev;
    assign keep_arr[w] = val & ({DW{1'b1}} >> (DW - 8*NB));
    assign wsel[w]     = (width == IW'(16 << w));
  end

  assign width_bad = (wsel == '0);

  always_comb begin
    res = '0;
    for (int w = 0; w < NW; w++)
      if (wsel[w]) res = big ? rev_arr[w] : keep_arr[w];
  end

  always_comb begin
    if (wsel[0]) begin
      assert_swap16_upper_zero_R6: assert (res[DW-1:16] == '0)
        else $error("16-bit swap left upper bits set");
      if (big)
        assert_swap16_order_R7: assert (res[7:0] == val[15:8] && res[15:8] == val[7:0])
          else $error("16-bit big-endian swap order wrong");
    end
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] dst_in,
  input  logic [DW-1:0] src_in,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] dst_out,
  output logic          invalid
);

  localparam int HW = DW / 2;

  opsel_t        sel;
  logic          use_reg, word32, bad_class, bad_op;
  logic [DW-1:0] operand, arith_res, swap_res;
  logic          width_bad;

  alu_decode u_dec (
    .opcode    (opcode),
    .sel       (sel),
    .use_reg   (use_reg),
    .word32    (word32),
    .bad_class (bad_class),
    .bad_op    (bad_op)
  );

  assign operand = use_reg ? src_in : {{(DW-IW){imm[IW-1]}}, imm};

  alu_arith #(.DW(DW)) u_arith (
    .sel    (sel),
    .word32 (word32),
    .a      (dst_in),
    .b      (operand),
    .res    (arith_res)
  );

  alu_byteswap #(.DW(DW), .IW(IW)) u_swap (
    .val       (dst_in),
    .big       (use_reg),
    .width     (imm),
    .res       (swap_res),
    .width_bad (width_bad)
  );

  assign invalid = bad_class || bad_op || (sel.is_swap && width_bad);
  assign dst_out = invalid ? dst_in : (sel.is_swap ? swap_res : arith_res);

  always_comb begin
    if (invalid)
      assert_invalid_hold_R9: assert (dst_out == dst_in)
        else $error("invalid encoding changed destination");
    if (!invalid && word32 && !sel.is_swap)
      assert_word_zero_ext_R4: assert (dst_out[DW-1:HW] == '0)
        else $error("word result not zero-extended");
    if (!invalid && sel.is_mov && use_reg && !word32)
      assert_mov_reg_R1: assert (dst_out == src_in)
        else $error("wide move from register mismatch");
  end

endmodule

// File: tb/alu_exec_tb.sv
module alu_exec_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [7:0]  opcode;
  logic [63:0] dst_in, src_in;
  logic [31:0] imm;
  logic [63:0] dst_out;
  logic        invalid;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec dut_i (
    .opcode  (opcode),
    .dst_in  (dst_in),
    .src_in  (src_in),
    .imm     (imm),
    .dst_out (dst_out),
    .invalid (invalid)
  );

  function automatic logic [63:0] pattern(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h0123_4567_89AB_CDEF;
      3: return 64'h8000_0000_7FFF_FFFF;
      4: return 64'hFEDC_BA98_8765_4321;
      default: return 64'h0000_0001_0000_0025;
    endcase
  endfunction

  function automatic logic [31:0] imm_pat(input int k);
    case (k)
      0: return 32'd16;
      1: return 32'd32;
      2: return 32'd64;
      3: return 32'd0;
      4: return 32'd8;
      5: return 32'hFFFF_FFF0;
      default: return 32'h8000_0003;
    endcase
  endfunction

  // independent reference model
  task automatic model(input logic [7:0] op, input logic [63:0] d, s,
                       input logic [31:0] im,
                       output logic [63:0] exp, output logic exp_inv);
    logic [3:0]  nib;
    logic [2:0]  cls;
    logic [63:0] b;
    logic [31:0] a32, b32, r32;
    int          nbytes;
    nib = op[7:4];
    cls = op[2:0];
    exp = d;
    exp_inv = 1'b1;
    b = op[3] ? s : 64'($signed(im));
    a32 = d[31:0];
    b32 = b[31:0];
    if (cls != 3'd4 && cls != 3'd7) return;
    if (nib == 4'hD) begin
      if (cls != 3'd4) return;
      if (im == 16) nbytes = 2;
      else if (im == 32) nbytes = 4;
      else if (im == 64) nbytes = 8;
      else return;
      exp = 64'h0;
      for (int i = 0; i < nbytes; i++) begin
        if (op[3]) exp = (exp << 8) | ((d >> (8*i)) & 64'hFF);
        else       exp = exp | (d & (64'hFF << (8*i)));
      end
      exp_inv = 1'b0;
      return;
    end
    exp_inv = 1'b0;
    if (cls == 3'd4) begin
      case (nib)
        4'h0: r32 = a32 + b32;
        4'h1: r32 = a32 - b32;
        4'h2: r32 = a32 * b32;
        4'hA: r32 = a32 ^ b32;
        4'hB: r32 = b32;
        4'hC: r32 = 32'($signed(a32) >>> (b32 & 32'd31));
        default: begin exp_inv = 1'b1; return; end
      endcase
      exp = {32'h0, r32};
    end else begin
      case (nib)
        4'h0: exp = d + b;
        4'h1: exp = d - b;
        4'h2: exp = d * b;
        4'hA: exp = d ^ b;
        4'hB: exp = b;
        4'hC: exp = 64'($signed(d) >>> (b & 64'd63));
        default: begin exp = d; exp_inv = 1'b1; end
      endcase
    end
  endtask

  function automatic string tag_of(input logic [7:0] op, input logic e_inv);
    if (op[2:0] != 3'd4 && op[2:0] != 3'd7) return "R2";
    if (e_inv) return "R9";
    if (op[7:4] == 4'hD) return op[3] ? "R7" : "R6";
    if (op[7:4] == 4'hC) return "R5";
    if (op[2:0] == 3'd4) return "R4";
    return op[3] ? "R1" : "R3";
  endfunction

  task automatic compare(input string tag, input logic [63:0] exp, input logic e_inv);
    n_cmp++;
    if (dst_out !== exp || invalid !== e_inv) begin
      n_bad++;
      $display("FAIL %s op=%h dst=%h src=%h imm=%h : got %h/%b expected %h/%b",
               tag, opcode, dst_in, src_in, imm, dst_out, invalid, exp, e_inv);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [63:0] d, s,
                       input logic [31:0] im);
    @(negedge clk);
    opcode = op; dst_in = d; src_in = s; imm = im;
    @(posedge clk);
    #1;
  endtask

  task automatic run_one(input logic [7:0] op, input logic [63:0] d, s,
                         input logic [31:0] im, input string force_tag);
    logic [63:0] e;
    logic        ei;
    apply(op, d, s, im);
    model(op, d, s, im, e, ei);
    compare(force_tag.len() != 0 ? force_tag : tag_of(op, ei), e, ei);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    opcode = 8'h0; dst_in = '0; src_in = '0; imm = '0;
    // idle inputs: class 0 is unsupported, destination held (R2)
    run_one(8'h00, 64'h0, 64'h0, 32'h0, "R2");

    // full opcode sweep
    for (int op = 0; op < 256; op++) begin
      for (int di = 0; di < 6; di++) begin
        if (op[7:4] == 4'hD) begin
          for (int ii = 0; ii < 7; ii++)
            run_one(8'(op), pattern(di), pattern(5 - di), imm_pat(ii), "");
        end else begin
          run_one(8'(op), pattern(di), pattern(5 - di), pattern(5 - di)[31:0], "");
          run_one(8'(op), pattern(di), pattern(di), 32'h8000_0041, "");
        end
      end
    end

    // R8: swap output independent of source register
    for (int si = 0; si < 6; si++) begin
      run_one(8'hDC, 64'h1122_3344_5566_7788, pattern(si), 32'd64, "R8");
      run_one(8'hD4, 64'h1122_3344_5566_7788, pattern(si), 32'd32, "R8");
    end

    // R7 explicit value, R6 explicit value
    apply(8'hDC, 64'h1122_3344_5566_7788, 64'h0, 32'd32);
    compare("R7", 64'h0000_0000_8877_6655, 1'b0);
    apply(8'hD4, 64'h1122_3344_5566_7788, 64'h0, 32'd16);
    compare("R6", 64'h0000_0000_0000_7788, 1'b0);

    // R5 boundaries: shift masking
    apply(8'hCF, 64'h8000_0000_0000_0000, 64'd65, 32'h0);
    compare("R5", 64'hC000_0000_0000_0000, 1'b0);
    apply(8'hCC, 64'h0000_0000_8000_0000, 64'd33, 32'h0);
    compare("R5", 64'h0000_0000_C000_0000, 1'b0);

    // R3: negative immediate sign-extended in wide add
    apply(8'h07, 64'd10, 64'h0, 32'hFFFF_FFFF);
    compare("R3", 64'd9, 1'b0);

    // R10: supported encodings report valid
    apply(8'hBF, 64'h5, 64'hABCD, 32'h0);
    compare("R10", 64'hABCD, 1'b0);
    apply(8'hDC, 64'h5, 64'h0, 32'd16);
    compare("R10", 64'h0500, 1'b0);

    // R9: swap in wide class and bad widths
    apply(8'hD7, 64'h1234, 64'h0, 32'd16);
    compare("R9", 64'h1234, 1'b1);
    apply(8'h3F, 64'h77, 64'h1, 32'h1);
    compare("R9", 64'h77, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule